// File: doc/BRIEF.md
# Periodic Battery-Low Monitor

This block decides when a backup battery gets tested and keeps the outcome. A check begins automatically in the cycle the external supply is first seen nominal. While the supply stays nominal, another check follows each time a fixed number of prescaled interval strobes has arrived. The default number of strobes gives 24 hours with a 1 Hz strobe. A check waits a programmable settle time and then samples a digital comparator input. That input is high when the battery is below roughly 2.5 V. Nothing is checked while the system runs from the battery.

The outcome drives the enable of an open-drain pull-down for an active-low battery-low pin. Two status bits tell the host what the result means. A low reading on a power-up check means retained data may be corrupt, so it sets a latched data-suspect bit. A low reading on a periodic check means the battery is wearing out while data is still intact, so it sets a periodic-source bit. All three outputs hold their values until a later check reads a good battery.

Top module: `batt_watch`

## Requirements
- R1: After reset, `batt_low_pull`, `data_suspect` and `low_periodic` are all 0.
- R2: The first cycle with `supply_ok` high after reset, or after any cycle with it low, starts a power-up check. If `batt_below` is 1 when that check samples, the three outputs become pull=1, suspect=1, periodic=0.
- R3: A check that samples `batt_below`=0 clears all three outputs to 0.
- R4: While `supply_ok` stays high, the TICKS_PER_CHECK-th `tick` pulse counted since power-up starts a periodic check, and so does each further group of TICKS_PER_CHECK pulses. If it samples `batt_below`=1, pull becomes 1 and periodic becomes 1, and `data_suspect` keeps its value.
- R5: While `supply_ok` is 0, `tick` and `batt_below` have no effect, and the outputs keep their values.
- R6: The interval count returns to zero whenever `supply_ok` is low. After the supply returns, a periodic check needs a full TICKS_PER_CHECK ticks.
- R7: A check started at clock edge E samples `batt_below` only at edge E+SETTLE_CYCLES. Values of `batt_below` before that edge do not affect the result.
- R8: If `supply_ok` falls during a check, the check is dropped and the outputs do not change.
- R9: `data_suspect` is never 1 while `batt_low_pull` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| supply_ok | input | 1 | External supply is nominal |
| tick | input | 1 | Prescaled interval strobe, one cycle wide |
| batt_below | input | 1 | Comparator: battery below threshold |
| batt_low_pull | output | 1 | 1 enables the pull-down of the active-low battery-low pin |
| data_suspect | output | 1 | A power-up check read a low battery |
| low_periodic | output | 1 | The last low result came from a periodic check |

## Verification
The hardest case to reach from the ports is telling a counter that restarted on a supply drop apart from one that kept its old count. The stimulus sends some ticks, drops the supply for a single cycle, and then sends fewer than a full interval of ticks with the comparator reading low. The pin must stay released until exactly one more tick arrives. The settle window is probed by changing the comparator on the last cycle before the sample edge. A mid-check abort is forced by dropping the supply two cycles into a check.

// File: rtl/batt_watch_pkg.sv
package batt_watch_pkg;

  typedef enum logic {CHK_IDLE, CHK_SETTLE} chk_state_e;

  typedef struct packed {
    logic low;
    logic suspect;
    logic periodic;
  } bw_flags_t;

  // Outcome of one sampled check given the flags held before it.
  function automatic bw_flags_t judge(bw_flags_t cur, logic below, logic from_pwrup);
    bw_flags_t n;
    if (!below) begin
      n = '0;
    end else begin
      n.low      = 1'b1;
      n.suspect  = cur.suspect | from_pwrup;
      n.periodic = ~from_pwrup;
    end
    return n;
  endfunction

  function automatic int cnt_width(int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/bw_interval.sv
module bw_interval #(
  parameter int TICKS_PER_CHECK = 86400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic tick,
  output logic due
);
  import batt_watch_pkg::*;

  localparam int CW = cnt_width(TICKS_PER_CHECK);
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_CHECK - 1);

  logic [CW-1:0] cnt;

  assign due = enable && tick && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!enable) cnt <= '0;
    else if (tick)    cnt <= due ? '0 : cnt + 1'b1;
  end

endmodule

// File: rtl/bw_sequencer.sv
module bw_sequencer #(
  parameter int SETTLE_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic start_pwrup,
  input  logic start_per,
  output logic sample_now,
  output logic kind_pwrup
);
  import batt_watch_pkg::*;

  localparam int SW = cnt_width(SETTLE_CYCLES);
  localparam logic [SW-1:0] LAST = SW'(SETTLE_CYCLES - 1);

  chk_state_e    state;
  logic [SW-1:0] cnt;

  assign sample_now = (state == CHK_SETTLE) && supply_ok && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= CHK_IDLE;
      cnt        <= '0;
      kind_pwrup <= 1'b0;
    end else begin
      case (state)
        CHK_IDLE: begin
          if (supply_ok && (start_pwrup || start_per)) begin
            state      <= CHK_SETTLE;
            cnt        <= '0;
            kind_pwrup <= start_pwrup;
          end
        end
        default: begin
          if (!supply_ok || cnt == LAST) state <= CHK_IDLE;
          else                           cnt   <= cnt + 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/bw_result.sv
module bw_result (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_now,
  input  logic kind_pwrup,
  input  logic batt_below,
  output batt_watch_pkg::bw_flags_t flags
);
  import batt_watch_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          flags <= '0;
    else if (sample_now) flags <= judge(flags, batt_below, kind_pwrup);
  end

endmodule

// File: rtl/batt_watch.sv
module batt_watch #(
  parameter int TICKS_PER_CHECK = 86400,
  parameter int SETTLE_CYCLES   = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic tick,
  input  logic batt_below,
  output logic batt_low_pull,
  output logic data_suspect,
  output logic low_periodic
);
  import batt_watch_pkg::*;

  logic      supply_q;
  logic      start_pwrup;
  logic      due;
  logic      sample_now;
  logic      kind_pwrup;
  bw_flags_t flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) supply_q <= 1'b0;
    else        supply_q <= supply_ok;
  end

  assign start_pwrup = supply_ok & ~supply_q;

  bw_interval #(.TICKS_PER_CHECK(TICKS_PER_CHECK)) u_interval (
    .clk(clk), .rst_n(rst_n), .enable(supply_ok), .tick(tick), .due(due)
  );

  bw_sequencer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok),
    .start_pwrup(start_pwrup), .start_per(due),
    .sample_now(sample_now), .kind_pwrup(kind_pwrup)
  );

  bw_result u_res (
    .clk(clk), .rst_n(rst_n), .sample_now(sample_now),
    .kind_pwrup(kind_pwrup), .batt_below(batt_below), .flags(flags)
  );

  assign batt_low_pull = flags.low;
  assign data_suspect  = flags.suspect;
  assign low_periodic  = flags.periodic;

endmodule

// File: rtl/bw_chk.sv
module bw_chk (
  input logic clk,
  input logic rst_n,
  input logic supply_ok,
  input logic batt_below,
  input logic start_pwrup,
  input logic due,
  input logic sample_now,
  input logic kind_pwrup,
  input logic batt_low_pull,
  input logic data_suspect,
  input logic low_periodic
);

  // R2
  pwrup_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_now && kind_pwrup && batt_below |=> batt_low_pull && data_suspect && !low_periodic);

  // R3
  good_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_now && !batt_below |=> !batt_low_pull && !data_suspect && !low_periodic);

  // R4
  periodic_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_now && !kind_pwrup && batt_below |=> batt_low_pull && low_periodic && $stable(data_suspect));

  // R5
  offline_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> $stable({batt_low_pull, data_suspect, low_periodic}));

  // R6
  no_due_at_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_pwrup |-> !due);

  // R7
  only_at_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_now |=> $stable({batt_low_pull, data_suspect, low_periodic}));

  // R9
  suspect_implies_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_suspect |-> batt_low_pull);

endmodule

bind batt_watch bw_chk u_chk (
  .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .batt_below(batt_below),
  .start_pwrup(start_pwrup), .due(due), .sample_now(sample_now),
  .kind_pwrup(kind_pwrup), .batt_low_pull(batt_low_pull),
  .data_suspect(data_suspect), .low_periodic(low_periodic)
);

// File: tb/sim_batt_watch.sv
module sim_batt_watch;
  localparam int TICKS  = 5;
  localparam int SETTLE = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_ok = 1'b0;
  logic tick = 1'b0;
  logic batt_below = 1'b0;
  logic batt_low_pull, data_suspect, low_periodic;
  int   n_run = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  batt_watch #(.TICKS_PER_CHECK(TICKS), .SETTLE_CYCLES(SETTLE)) u0 (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .tick(tick),
    .batt_below(batt_below), .batt_low_pull(batt_low_pull),
    .data_suspect(data_suspect), .low_periodic(low_periodic)
  );

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // Expected flags written as {pull, suspect, periodic}.
  task automatic check(string req, logic [2:0] exp);
    logic [2:0] act;
    act = {batt_low_pull, data_suspect, low_periodic};
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic pulse_tick();
    tick = 1'b1; cyc(1); tick = 1'b0;
  endtask

  // Raise the supply and wait until the power-up check has sampled.
  task automatic power_up(logic below);
    batt_below = below;
    supply_ok = 1'b1;
    cyc(SETTLE + 1);
  endtask

  task automatic power_down();
    supply_ok = 1'b0; cyc(2);
  endtask

  task automatic t_reset();
    cyc(1); check("R1 reset", 3'b000);
    rst_n = 1'b1; cyc(2); check("R1 after release", 3'b000);
  endtask

  task automatic t_pwrup_low();
    power_up(1'b1); check("R2 power-up low", 3'b110);
  endtask

  task automatic t_periodic_keeps_suspect();
    repeat (TICKS - 1) pulse_tick();
    check("R4 no check before interval", 3'b110);
    pulse_tick(); cyc(SETTLE);
    check("R4 periodic low keeps suspect", 3'b111);
  endtask

  task automatic t_periodic_good();
    batt_below = 1'b0;
    repeat (TICKS) pulse_tick();
    cyc(SETTLE);
    check("R3 periodic good clears", 3'b000);
    batt_below = 1'b1;
    repeat (TICKS) pulse_tick();
    cyc(SETTLE);
    check("R4 periodic low only", 3'b101);
  endtask

  task automatic t_offline();
    power_down();
    batt_below = 1'b0;
    repeat (2 * TICKS) pulse_tick();
    batt_below = 1'b1; cyc(3);
    check("R5 offline ignores inputs", 3'b101);
  endtask

  task automatic t_abort();
    batt_below = 1'b0;
    supply_ok = 1'b1; cyc(2);
    supply_ok = 1'b0; cyc(SETTLE + 3);
    check("R8 aborted check no update", 3'b101);
  endtask

  task automatic t_settle_window();
    // Low during settle, good only at the sample edge.
    batt_below = 1'b1;
    supply_ok = 1'b1; cyc(SETTLE);
    batt_below = 1'b0; cyc(1);
    check("R7 late good sampled", 3'b000);
    power_down();
    // Good during settle, low only at the sample edge.
    batt_below = 1'b0;
    supply_ok = 1'b1; cyc(SETTLE);
    batt_below = 1'b1; cyc(1);
    check("R7 late low sampled", 3'b110);
    power_down();
  endtask

  task automatic t_interval_restart();
    power_up(1'b0); check("R3 power-up good clears", 3'b000);
    repeat (TICKS - 2) pulse_tick();
    supply_ok = 1'b0; cyc(1);
    power_up(1'b0); check("R2 second power-up good", 3'b000);
    batt_below = 1'b1;
    repeat (TICKS - 1) pulse_tick();
    cyc(SETTLE + 1);
    check("R6 count restarted", 3'b000);
    pulse_tick(); cyc(SETTLE);
    check("R6 full interval after return", 3'b101);
  endtask

  initial begin
    t_reset();
    t_pwrup_low();
    t_periodic_keeps_suspect();
    t_periodic_good();
    t_offline();
    t_abort();
    t_settle_window();
    t_interval_restart();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule